// File: doc/BRIEF.md
# Runahead Mode Retirement Controller

This block decides, cycle by cycle, what happens to the oldest entry of an out-of-order core's instruction window. In normal mode it retires the head entry to architectural state once that entry has completed. When the head is an incomplete load that missed in the second-level cache, it does not let the core stall. It asks for a checkpoint of the architectural registers, records the tag of that miss and switches the core into runahead mode.

In runahead mode nothing is retired architecturally; entries are only pseudo-retired so the window keeps draining and later misses are found early. An entry whose result is poisoned (flagged INV) or which is itself a new cache miss is dropped at once. A healthy entry waits until it has executed. A pseudo-retired store sends its address, data and poison flag to a small runahead store memory. A per-register poison vector records which destination registers hold untrustworthy values.

When the miss with the recorded tag returns, the controller strobes checkpoint restore together with a pipeline flush, clears the poison vector and drops back to normal mode on the next cycle.

Top module: `ra_retire_ctrl`

## Requirements
- R1: While reset is high and at the first cycle after it, runahead is 0, the poison vector is all zero, and with an idle head every strobe (ckpt_save, ckpt_restore, flush, pop, arch_retire, rc_wr_en) is 0.
- R2: In normal mode a valid head with head_done=1 is popped with arch_retire=1 in the same cycle. A valid head that is incomplete and not a cache miss is never popped.
- R3: In normal mode a valid, incomplete head with head_l2miss=1 raises ckpt_save and pop for that one cycle without arch_retire. It captures head_tag, and runahead reads 1 from the next cycle on.
- R4: While runahead is 1, arch_retire and ckpt_save stay 0.
- R5: While runahead is 1, a valid head with head_inv=1 or head_l2miss=1 is popped in the same cycle whatever head_done is.
- R6: While runahead is 1, a valid head with head_inv=0 and head_l2miss=0 is popped only when head_done=1.
- R7: A store (head_store=1) pseudo-retired in runahead mode raises rc_wr_en in that cycle, with rc_wr_addr, rc_wr_data equal to head_st_addr, head_st_data and rc_wr_inv equal to head_inv. No write happens in normal mode.
- R8: reg_inv bit k (k = head_dst) is set at the edge after the entry cycle when head_dst_valid=1. An entry pseudo-retired with head_dst_valid=1 sets bit k to head_inv OR head_l2miss. The whole vector clears at the edge ending the exit cycle.
- R9: While runahead is 1, ret_valid=1 with ret_tag equal to the captured tag raises ckpt_restore and flush for that cycle, with pop=0. runahead reads 0 from the next cycle.
- R10: A return whose tag differs from the captured tag, or any return in normal mode, causes no restore, no flush and no change of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_valid | input | 1 | Window head holds an entry |
| head_done | input | 1 | Head entry has finished executing |
| head_l2miss | input | 1 | Head is a load with an outstanding second-level miss |
| head_inv | input | 1 | Head result is poisoned by a miss |
| head_store | input | 1 | Head is a store |
| head_dst_valid | input | 1 | Head writes a destination register |
| head_dst | input | REG_W | Destination register index of the head |
| head_tag | input | TAG_W | Miss tag of the head load |
| head_st_addr | input | ADDR_W | Store address of the head |
| head_st_data | input | DATA_W | Store data of the head |
| ret_valid | input | 1 | A miss returns from memory this cycle |
| ret_tag | input | TAG_W | Tag of the returning miss |
| ckpt_save | output | 1 | Take the architectural checkpoint |
| ckpt_restore | output | 1 | Restore the architectural checkpoint |
| flush | output | 1 | Flush the pipeline |
| pop | output | 1 | Remove the window head |
| arch_retire | output | 1 | Head is committed to architectural state |
| runahead | output | 1 | Core is in runahead mode |
| rc_wr_en | output | 1 | Write to the runahead store memory |
| rc_wr_addr | output | ADDR_W | Address of that write |
| rc_wr_data | output | DATA_W | Data of that write |
| rc_wr_inv | output | 1 | Poison flag of that write |
| reg_inv | output | NREG | Per-register poison bits |

## Verification
The bench builds the controller with 4-bit tags, 8 registers and narrow 8-bit addresses and 16-bit data. With only sixteen tag values, random returns often hit the captured tag and often miss it, so both exits and ignored returns happen many times. With eight registers, random destinations revisit the same poison bit within a few pseudo-retirements, so setting, overwriting and clearing on exit all occur on the same bits.

// File: rtl/ra_pkg.sv
package ra_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_AHEAD  = 1'b1
    } ra_mode_e;

    typedef struct packed {
        logic valid;
        logic done;
        logic l2miss;
        logic inv;
        logic store;
        logic dst_valid;
    } head_flags_t;

    // head triggers a switch into runahead (normal mode only)
    function automatic logic is_entry_trigger(head_flags_t f);
        return f.valid && !f.done && f.l2miss;
    endfunction

    // head may leave the window in normal mode
    function automatic logic can_commit(head_flags_t f);
        return f.valid && f.done;
    endfunction

    // head may leave the window in runahead mode
    function automatic logic can_drop(head_flags_t f);
        return f.valid && (f.inv || f.l2miss || f.done);
    endfunction

    // poison value a dropped head leaves in its destination
    function automatic logic poison_of(head_flags_t f);
        return f.inv || f.l2miss;
    endfunction

endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm #(
    parameter int TAG_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  ra_pkg::head_flags_t flags,
    input  logic [TAG_W-1:0]    head_tag,
    input  logic                ret_valid,
    input  logic [TAG_W-1:0]    ret_tag,
    output ra_pkg::ra_mode_e    mode,
    output logic                enter_now,
    output logic                exit_now
);
    import ra_pkg::*;

    ra_mode_e         mode_q;
    logic [TAG_W-1:0] trig_tag_q;

    always_comb begin
        enter_now = (mode_q == MODE_NORMAL) && is_entry_trigger(flags);
        exit_now  = (mode_q == MODE_AHEAD) && ret_valid && (ret_tag == trig_tag_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_NORMAL;
            trig_tag_q <= '0;
        end else if (enter_now) begin
            mode_q     <= MODE_AHEAD;
            trig_tag_q <= head_tag;
        end else if (exit_now) begin
            mode_q     <= MODE_NORMAL;
        end
    end

    assign mode = mode_q;

    // R3: mode only rises after a checkpoint request
    a_r3_rise_after_save: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_AHEAD) && ($past(mode_q) == MODE_NORMAL) |-> $past(enter_now));

    // R9: leaving runahead needs a matching return in the previous cycle
    a_r9_fall_after_match: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NORMAL) && ($past(mode_q) == MODE_AHEAD) |-> $past(ret_valid));

    // R10: a non-matching return keeps the mode
    a_r10_mismatch_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_AHEAD) && !(ret_valid && ret_tag == trig_tag_q) |=> (mode_q == MODE_AHEAD));

endmodule

// File: rtl/ra_pseudo_retire.sv
module ra_pseudo_retire #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  ra_pkg::head_flags_t flags,
    input  ra_pkg::ra_mode_e    mode,
    input  logic                enter_now,
    input  logic                exit_now,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [DATA_W-1:0]   st_data,
    output logic                pop,
    output logic                arch_retire,
    output logic                drop,
    output logic                rc_wr_en,
    output logic [ADDR_W-1:0]   rc_wr_addr,
    output logic [DATA_W-1:0]   rc_wr_data,
    output logic                rc_wr_inv
);
    import ra_pkg::*;

    logic ahead;

    always_comb begin
        ahead       = (mode == MODE_AHEAD);
        drop        = ahead && !exit_now && can_drop(flags);
        arch_retire = !ahead && can_commit(flags);
        pop         = ahead ? drop : (arch_retire || enter_now);
        rc_wr_en    = drop && flags.store;
        rc_wr_addr  = st_addr;
        rc_wr_data  = st_data;
        rc_wr_inv   = flags.inv;
    end

    // R2: normal mode never pops an incomplete head except at entry
    a_r2_no_early_pop: assert property (@(posedge clk) disable iff (rst)
        pop && !ahead && !enter_now |-> flags.done);

    // R6: a healthy head leaves runahead only when executed
    a_r6_valid_waits: assert property (@(posedge clk) disable iff (rst)
        pop && ahead && !flags.inv && !flags.l2miss |-> flags.done);

    // R7: store memory writes only for popped stores
    a_r7_write_is_store: assert property (@(posedge clk) disable iff (rst)
        rc_wr_en |-> pop && flags.store && flags.valid);

endmodule

// File: rtl/ra_inv_tracker.sv
module ra_inv_tracker #(
    parameter int NREG  = 32,
    parameter int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_idx,
    input  logic             set_val,
    output logic [NREG-1:0]  inv_bits
);
    for (genvar k = 0; k < NREG; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                inv_bits[k] <= 1'b0;
            end else if (set_en && set_idx == REG_W'(k)) begin
                inv_bits[k] <= set_val;
            end
        end
    end

    // R8: untouched bits hold their value
    a_r8_only_target_changes: assert property (@(posedge clk) disable iff (rst)
        !clear && !set_en |=> $stable(inv_bits));

endmodule

// File: rtl/ra_retire_ctrl.sv
module ra_retire_ctrl #(
    parameter int TAG_W  = 6,
    parameter int NREG   = 32,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              head_valid,
    input  logic              head_done,
    input  logic              head_l2miss,
    input  logic              head_inv,
    input  logic              head_store,
    input  logic              head_dst_valid,
    input  logic [REG_W-1:0]  head_dst,
    input  logic [TAG_W-1:0]  head_tag,
    input  logic [ADDR_W-1:0] head_st_addr,
    input  logic [DATA_W-1:0] head_st_data,
    input  logic              ret_valid,
    input  logic [TAG_W-1:0]  ret_tag,
    output logic              ckpt_save,
    output logic              ckpt_restore,
    output logic              flush,
    output logic              pop,
    output logic              arch_retire,
    output logic              runahead,
    output logic              rc_wr_en,
    output logic [ADDR_W-1:0] rc_wr_addr,
    output logic [DATA_W-1:0] rc_wr_data,
    output logic              rc_wr_inv,
    output logic [NREG-1:0]   reg_inv
);
    import ra_pkg::*;

    head_flags_t hf;
    ra_mode_e    mode;
    logic        enter_now;
    logic        exit_now;
    logic        drop;
    logic        mark_en;
    logic        mark_val;

    always_comb begin
        hf.valid     = head_valid;
        hf.done      = head_done;
        hf.l2miss    = head_l2miss;
        hf.inv       = head_inv;
        hf.store     = head_store;
        hf.dst_valid = head_dst_valid;
    end

    ra_mode_fsm #(.TAG_W(TAG_W)) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .flags     (hf),
        .head_tag  (head_tag),
        .ret_valid (ret_valid),
        .ret_tag   (ret_tag),
        .mode      (mode),
        .enter_now (enter_now),
        .exit_now  (exit_now)
    );

    ra_pseudo_retire #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_retire (
        .clk         (clk),
        .rst         (rst),
        .flags       (hf),
        .mode        (mode),
        .enter_now   (enter_now),
        .exit_now    (exit_now),
        .st_addr     (head_st_addr),
        .st_data     (head_st_data),
        .pop         (pop),
        .arch_retire (arch_retire),
        .drop        (drop),
        .rc_wr_en    (rc_wr_en),
        .rc_wr_addr  (rc_wr_addr),
        .rc_wr_data  (rc_wr_data),
        .rc_wr_inv   (rc_wr_inv)
    );

    // the triggering load always leaves a poisoned destination
    always_comb begin
        mark_en  = head_dst_valid && (enter_now || drop);
        mark_val = enter_now ? 1'b1 : poison_of(hf);
    end

    ra_inv_tracker #(.NREG(NREG), .REG_W(REG_W)) i_inv (
        .clk      (clk),
        .rst      (rst),
        .clear    (exit_now),
        .set_en   (mark_en),
        .set_idx  (head_dst),
        .set_val  (mark_val),
        .inv_bits (reg_inv)
    );

    assign runahead     = (mode == MODE_AHEAD);
    assign ckpt_save    = enter_now;
    assign ckpt_restore = exit_now;
    assign flush        = exit_now;

    // R4: no architectural commit and no new checkpoint in runahead
    a_r4_no_commit_ahead: assert property (@(posedge clk) disable iff (rst)
        runahead |-> !arch_retire && !ckpt_save);

    // R9: restore comes with flush, no pop, then normal mode with clean poison bits
    a_r9_restore_no_pop: assert property (@(posedge clk) disable iff (rst)
        ckpt_restore |-> flush && !pop);
    a_r9_exit_clean: assert property (@(posedge clk) disable iff (rst)
        ckpt_restore |=> !runahead && (reg_inv == '0));

    // R8: destination of the triggering load is poisoned
    a_r8_entry_poison: assert property (@(posedge clk) disable iff (rst)
        ckpt_save && head_dst_valid |=> reg_inv[$past(head_dst)]);

    // R10: a return in normal mode never restores
    a_r10_normal_return: assert property (@(posedge clk) disable iff (rst)
        !runahead |-> !ckpt_restore);

    // R1: normal mode carries no poison
    a_r1_clean_normal: assert property (@(posedge clk) disable iff (rst)
        !runahead && !$past(runahead) |-> reg_inv == '0);

endmodule

// File: tb/test_ra_retire_ctrl.sv
module test_ra_retire_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W  = 4;
    localparam int NREG   = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int REG_W  = $clog2(NREG);

    logic clk = 1'b0;
    logic rst;
    logic head_valid, head_done, head_l2miss, head_inv, head_store, head_dst_valid;
    logic [REG_W-1:0]  head_dst;
    logic [TAG_W-1:0]  head_tag;
    logic [ADDR_W-1:0] head_st_addr;
    logic [DATA_W-1:0] head_st_data;
    logic              ret_valid;
    logic [TAG_W-1:0]  ret_tag;
    logic ckpt_save, ckpt_restore, flush, pop, arch_retire, runahead;
    logic rc_wr_en, rc_wr_inv;
    logic [ADDR_W-1:0] rc_wr_addr;
    logic [DATA_W-1:0] rc_wr_data;
    logic [NREG-1:0]   reg_inv;

    always #(CLK_PERIOD/2) clk = ~clk;

    ra_retire_ctrl #(.TAG_W(TAG_W), .NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ra_retire_ctrl (
        .clk(clk), .rst(rst),
        .head_valid(head_valid), .head_done(head_done), .head_l2miss(head_l2miss),
        .head_inv(head_inv), .head_store(head_store), .head_dst_valid(head_dst_valid),
        .head_dst(head_dst), .head_tag(head_tag), .head_st_addr(head_st_addr),
        .head_st_data(head_st_data), .ret_valid(ret_valid), .ret_tag(ret_tag),
        .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore), .flush(flush), .pop(pop),
        .arch_retire(arch_retire), .runahead(runahead), .rc_wr_en(rc_wr_en),
        .rc_wr_addr(rc_wr_addr), .rc_wr_data(rc_wr_data), .rc_wr_inv(rc_wr_inv),
        .reg_inv(reg_inv)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // behavioural reference state
    bit              m_run = 0;
    int              m_tag = 0;
    logic [NREG-1:0] m_inv = '0;

    task automatic chk(input string ctx, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", ctx, req, act, exp, $time);
        end
    endtask

    // apply one cycle of stimulus, compare against the model, advance the model
    task automatic drive(input bit r, input bit v, input bit d, input bit m, input bit i,
                         input bit s, input bit dv, input int dst, input int tag,
                         input bit rv, input int rt, input string ctx);
        bit e_exit, e_enter, e_pop, e_arch, e_wr;
        rst = r; head_valid = v; head_done = d; head_l2miss = m; head_inv = i;
        head_store = s; head_dst_valid = dv; head_dst = REG_W'(dst); head_tag = TAG_W'(tag);
        head_st_addr = ADDR_W'($urandom); head_st_data = DATA_W'($urandom);
        ret_valid = rv; ret_tag = TAG_W'(rt);
        #1;
        e_exit  = m_run && rv && ((rt % (1 << TAG_W)) == m_tag);
        e_enter = !m_run && v && !d && m;
        e_arch  = !m_run && v && d;
        if (m_run) e_pop = !e_exit && v && (i || m || d);
        else       e_pop = e_arch || e_enter;
        e_wr = m_run && e_pop && s;
        chk(ctx, "R1/R4 runahead", 64'(runahead), 64'(m_run));
        chk(ctx, "R3 ckpt_save", 64'(ckpt_save), 64'(e_enter));
        chk(ctx, "R9 ckpt_restore", 64'(ckpt_restore), 64'(e_exit));
        chk(ctx, "R9 flush", 64'(flush), 64'(e_exit));
        chk(ctx, "R5 pop", 64'(pop), 64'(e_pop));
        chk(ctx, "R2 arch_retire", 64'(arch_retire), 64'(e_arch));
        chk(ctx, "R7 rc_wr_en", 64'(rc_wr_en), 64'(e_wr));
        if (e_wr) begin
            chk(ctx, "R7 rc_wr_inv", 64'(rc_wr_inv), 64'(i));
            chk(ctx, "R7 rc_wr_addr", 64'(rc_wr_addr), 64'(head_st_addr));
            chk(ctx, "R7 rc_wr_data", 64'(rc_wr_data), 64'(head_st_data));
        end
        chk(ctx, "R8 reg_inv", 64'(reg_inv), 64'(m_inv));
        // next model state
        if (r) begin
            m_run = 0; m_tag = 0; m_inv = '0;
        end else if (e_exit) begin
            m_run = 0; m_inv = '0;
        end else if (e_enter) begin
            m_run = 1; m_tag = tag % (1 << TAG_W);
            if (dv) m_inv[dst % NREG] = 1'b1;
        end else if (m_run && e_pop && dv) begin
            m_inv[dst % NREG] = i || m;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        drive(1, 0,0,0,0,0,0, 0,0, 0,0, "R1 reset");
        drive(1, 1,0,1,0,0,1, 2,3, 0,0, "R1 reset miss");
        drive(0, 0,0,0,0,0,0, 0,0, 0,0, "R1 idle");
        // R2: normal retirement
        drive(0, 1,1,0,0,0,1, 2,0, 0,0, "R2 commit");
        drive(0, 1,0,0,0,0,1, 2,0, 0,0, "R2 incomplete");
        drive(0, 1,0,0,1,1,0, 0,0, 0,0, "R7 normal store");
        drive(0, 0,0,0,0,0,0, 0,0, 1,5, "R10 return in normal");
        // R3: entry on miss tag 5, destination 3
        drive(0, 1,0,1,0,0,1, 3,5, 0,0, "R3 entry");
        drive(0, 1,0,0,0,0,1, 1,0, 0,0, "R6 waits");
        drive(0, 1,1,0,0,0,1, 1,0, 0,0, "R6 done");
        drive(0, 1,0,0,1,0,1, 2,0, 0,0, "R5 inv drop");
        drive(0, 1,0,1,0,0,1, 4,9, 0,0, "R5 miss drop");
        drive(0, 1,0,0,1,1,0, 0,0, 0,0, "R7 inv store");
        drive(0, 1,1,0,0,1,0, 0,0, 0,0, "R7 valid store");
        drive(0, 1,1,0,0,0,0, 0,0, 0,0, "R4 no commit");
        drive(0, 1,0,0,1,0,1, 4,0, 1,6, "R10 wrong tag");
        drive(0, 1,0,0,1,0,1, 5,0, 1,5, "R9 exit");
        drive(0, 0,0,0,0,0,0, 0,0, 0,0, "R9 after exit");
        drive(0, 1,0,0,0,0,0, 0,0, 0,0, "R2 incomplete again");
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            int rt;
            rt = ($urandom % 3 == 0) ? m_tag : int'($urandom % (1 << TAG_W));
            drive(0, $urandom%4 != 0, $urandom%2 == 0, $urandom%4 == 0, $urandom%4 == 0,
                  $urandom%3 == 0, $urandom%2 == 0, int'($urandom % NREG), int'($urandom % 16),
                  $urandom%6 == 0, rt, "mixed");
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule